// File: doc/BRIEF.md
# Way-Filtered Branch Target Buffer

This block is a 4-way, 512-set branch target buffer. In front of the main array sits a small partial-tag table. For each set it holds one 6-bit slice of the stored tag per way. A fetch lookup reads that table once and compares all four slices with the same slice of the PC. The result is a candidate-way vector. Only the ways flagged in that vector are read from the main array, and there they are checked on the rest of the tag. When no way is a candidate, the lookup is answered as a miss one cycle after the request and the main array is not touched at all. A lookup that does reach the main array answers one cycle later, two cycles after the request.

The 6-bit slice is taken out of the stored tag, not added to it. A main-array slot keeps only the remaining tag bits, the branch target and a branch-kind code. The per-set valid bits live in resettable flops beside the table, so an empty way never becomes a candidate. One update port writes the partial-tag slot and the main-array slot on the same clock edge. Its victim choice is, in order: a way that already holds the same tag, then the lowest-numbered empty way, then a per-set round-robin pointer. Per-way read enables are brought out, so the gating of the main array can be observed.

Top module: `wayFilteredBtb`

## Requirements
- R1: During and after a synchronous active-low reset, `respValid`, `fastMiss` and `wayRdEn` are 0, and every way of every set is empty, so the first lookups all miss.
- R2: PC field layout: PC[10:2] is the set index, PC[16:11] is the partial tag, PC[31:17] is the remaining tag, and PC[1:0] has no effect on lookup or update.
- R3: The candidate vector holds bit w (bit 0 = way 0) set exactly when way w of the indexed set is valid and its stored partial tag equals PC[16:11]. It is reported on `respWays` with the response.
- R4: A lookup whose candidate vector is zero raises `fastMiss` for one cycle, in the cycle after the request. It asserts no `wayRdEn` bit and produces no `respValid`.
- R5: A lookup whose candidate vector is nonzero drives `wayRdEn` equal to that vector in the cycle after the request, and `respValid` in the cycle after that.
- R6: `respHit` is 1 only when one way has a partial-tag match, a remaining-tag match and its valid bit set. `respTarget` and `respKind` then carry that way's stored target and kind. A candidate whose remaining tag differs gives `respValid` with `respHit` 0.
- R7: An update writes the partial tag, remaining tag, target and kind into one way on one clock edge. A lookup requested in the next cycle sees the new entry.
- R8: An update whose full tag is already stored, valid, in the set rewrites that same way. No second copy is made.
- R9: Otherwise the update takes the lowest-numbered empty way of the set.
- R10: When the set is full and holds no matching tag, the update takes the way named by the set's round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping 3 to 0) only on such replacements, and is kept separately for each set.
- R11: A lookup and an update in the same cycle to the same set are answered from the contents before the update. The way being overwritten is dropped from the candidate vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lkValid | input | 1 | Lookup request strobe |
| lkPc | input | 32 | PC to look up |
| updValid | input | 1 | Update strobe |
| updPc | input | 32 | PC of the branch being installed |
| updTarget | input | 32 | Target to store |
| updKind | input | 2 | Branch-kind code to store |
| respValid | output | 1 | Main-array response for a lookup made two cycles earlier |
| respHit | output | 1 | Response hit flag |
| respTarget | output | 32 | Target of the hitting way |
| respKind | output | 2 | Kind code of the hitting way |
| respWays | output | 4 | Candidate vector of the responding lookup |
| fastMiss | output | 1 | Filtered miss for a lookup made one cycle earlier |
| wayRdEn | output | 4 | Per-way main-array read enable |

## Verification
Three things can fall in the same cycle. The fast miss of a newer lookup can come out together with the main-array response of the lookup before it. The bench provokes this by issuing, back to back, a PC that hits and then a PC with no partial-tag match, and it judges both outputs against its own two-deep pipeline of expected results. An update can also land in the same cycle as a lookup to the same set. The bench drives both on one edge, on purpose and in a long random stream confined to four sets and a few tags. The reference model answers from the old contents with the victim way removed.

// File: rtl/btbPkg.sv
package btbPkg;

  // Strobes from control to datapath, one cycle's worth.
  typedef struct packed {
    logic s1Load;   // capture a new lookup into stage 1
    logic s2Load;   // stage 1 reads the main array and fills the response
    logic wrEn;     // write one way of the update set
  } btbStrobe_t;

endpackage

// File: rtl/btbCtrl.sv
module btbCtrl
  import btbPkg::*;
#(
  parameter int SETS = 512,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WIDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             updValid,
  input  logic [IDX_W-1:0] updSet,
  input  logic             s1Any,
  input  logic [WAYS-1:0]  updMatch,
  input  logic [WAYS-1:0]  updOccupied,
  output btbStrobe_t       strb,
  output logic [WAYS-1:0]  wrWay,
  output logic             s1Valid,
  output logic             s2Valid
);

  logic [WIDX_W-1:0] rrCnt [SETS];
  logic              rrUse;
  logic              s1ValidQ;
  logic              s2ValidQ;

  // Victim choice: same tag, then lowest empty way, then round robin.
  always_comb begin
    wrWay = '0;
    rrUse = 1'b0;
    if (|updMatch) begin
      wrWay = updMatch;
    end else if (!(&updOccupied)) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!updOccupied[w]) begin
          wrWay    = '0;
          wrWay[w] = 1'b1;
        end
      end
    end else begin
      wrWay[rrCnt[updSet]] = 1'b1;
      rrUse = 1'b1;
    end
  end

  always_comb begin
    strb.s1Load = lkValid;
    strb.s2Load = s1ValidQ & s1Any;
    strb.wrEn   = updValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1ValidQ <= 1'b0;
      s2ValidQ <= 1'b0;
      for (int s = 0; s < SETS; s++) rrCnt[s] <= '0;
    end else begin
      s1ValidQ <= lkValid;
      s2ValidQ <= strb.s2Load;
      if (updValid && rrUse) rrCnt[updSet] <= rrCnt[updSet] + 1'b1;
    end
  end

  assign s1Valid = s1ValidQ;
  assign s2Valid = s2ValidQ;

endmodule

// File: rtl/btbDatapath.sv
module btbDatapath
  import btbPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int OFS_W  = 2,
  parameter int SETS   = 512,
  parameter int WAYS   = 4,
  parameter int PTAG_W = 6,
  parameter int TGT_W  = 32,
  parameter int KIND_W = 2,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = PC_W - OFS_W - IDX_W,
  localparam int REST_W = TAG_W - PTAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  btbStrobe_t        strb,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic [TGT_W-1:0]  updTarget,
  input  logic [KIND_W-1:0] updKind,
  input  logic [WAYS-1:0]   wrWay,
  output logic              s1Any,
  output logic [IDX_W-1:0]  updSet,
  output logic [WAYS-1:0]   updMatch,
  output logic [WAYS-1:0]   updOccupied,
  output logic [WAYS-1:0]   wayRdEn,
  output logic              respHit,
  output logic [TGT_W-1:0]  respTarget,
  output logic [KIND_W-1:0] respKind,
  output logic [WAYS-1:0]   respWays
);

  typedef struct packed {
    logic [REST_W-1:0] rest;
    logic [TGT_W-1:0]  target;
    logic [KIND_W-1:0] kind;
  } slot_t;

  // Storage: partial-tag table, main array, per-set valid flops.
  logic [PTAG_W-1:0] ptagTab [SETS][WAYS];
  slot_t             mainArr [SETS][WAYS];
  logic [WAYS-1:0]   validQ  [SETS];

  // PC fields.
  logic [IDX_W-1:0]  lkSet;
  logic [PTAG_W-1:0] lkPtag, updPtag;
  logic [REST_W-1:0] lkRest, updRest;
  logic              unusedPcLow;

  assign lkSet   = lkPc[OFS_W +: IDX_W];
  assign lkPtag  = lkPc[OFS_W + IDX_W +: PTAG_W];
  assign lkRest  = lkPc[PC_W-1 -: REST_W];
  assign updSet  = updPc[OFS_W +: IDX_W];
  assign updPtag = updPc[OFS_W + IDX_W +: PTAG_W];
  assign updRest = updPc[PC_W-1 -: REST_W];
  assign unusedPcLow = ^{lkPc[OFS_W-1:0], updPc[OFS_W-1:0]};

  // Stage 1 state.
  logic [IDX_W-1:0]  s1Set;
  logic [REST_W-1:0] s1Rest;
  logic [WAYS-1:0]   s1Cand;
  logic [WAYS-1:0]   candNow;
  logic [WAYS-1:0]   hitVec;
  slot_t             rdSlot [WAYS];
  logic              sameSetWr;

  assign sameSetWr   = strb.wrEn && (updSet == lkSet);
  assign updOccupied = validQ[updSet];
  assign s1Any       = |s1Cand;
  assign wayRdEn     = strb.s2Load ? s1Cand : '0;

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    // Filter compare; an overwritten way is dropped from the vector.
    assign candNow[w] = validQ[lkSet][w] && (ptagTab[lkSet][w] == lkPtag)
                        && !(sameSetWr && wrWay[w]);
    // Full-tag match on the update side, for in-place rewrite.
    assign updMatch[w] = validQ[updSet][w] && (ptagTab[updSet][w] == updPtag)
                         && (mainArr[updSet][w].rest == updRest);
    // Gated main-array read and remaining-tag compare.
    assign rdSlot[w] = wayRdEn[w] ? mainArr[s1Set][w] : '0;
    assign hitVec[w] = wayRdEn[w] && (rdSlot[w].rest == s1Rest);
  end

  logic [TGT_W-1:0]  hitTarget;
  logic [KIND_W-1:0] hitKind;

  always_comb begin
    hitTarget = '0;
    hitKind   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitTarget = hitTarget | rdSlot[w].target;
        hitKind   = hitKind | rdSlot[w].kind;
      end
    end
  end

  // Arrays without reset; they are qualified by validQ.
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wrWay[w]) begin
          ptagTab[updSet][w] <= updPtag;
          mainArr[updSet][w] <= '{rest: updRest, target: updTarget, kind: updKind};
        end
      end
    end
    if (strb.s1Load) begin
      s1Set  <= lkSet;
      s1Rest <= lkRest;
      s1Cand <= candNow;
    end
  end

  logic              respHitQ;
  logic [TGT_W-1:0]  respTargetQ;
  logic [KIND_W-1:0] respKindQ;
  logic [WAYS-1:0]   respWaysQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
      respHitQ    <= 1'b0;
      respTargetQ <= '0;
      respKindQ   <= '0;
      respWaysQ   <= '0;
    end else begin
      if (strb.wrEn) validQ[updSet] <= validQ[updSet] | wrWay;
      if (strb.s2Load) begin
        respHitQ    <= |hitVec;
        respTargetQ <= hitTarget;
        respKindQ   <= hitKind;
        respWaysQ   <= s1Cand;
      end
    end
  end

  assign respHit    = respHitQ;
  assign respTarget = respTargetQ;
  assign respKind   = respKindQ;
  assign respWays   = respWaysQ;

endmodule

// File: rtl/wayFilteredBtb.sv
module wayFilteredBtb
  import btbPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int OFS_W  = 2,
  parameter int SETS   = 512,
  parameter int WAYS   = 4,
  parameter int PTAG_W = 6,
  parameter int TGT_W  = 32,
  parameter int KIND_W = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [PC_W-1:0]   lkPc,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [TGT_W-1:0]  updTarget,
  input  logic [KIND_W-1:0] updKind,
  output logic              respValid,
  output logic              respHit,
  output logic [TGT_W-1:0]  respTarget,
  output logic [KIND_W-1:0] respKind,
  output logic [WAYS-1:0]   respWays,
  output logic              fastMiss,
  output logic [WAYS-1:0]   wayRdEn
);

  btbStrobe_t       strb;
  logic [WAYS-1:0]  wrWay;
  logic [WAYS-1:0]  updMatch;
  logic [WAYS-1:0]  updOccupied;
  logic [IDX_W-1:0] updSet;
  logic             s1Any;
  logic             s1Valid;

  btbCtrl #(.SETS(SETS), .WAYS(WAYS)) uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .updValid(updValid),
    .updSet(updSet), .s1Any(s1Any), .updMatch(updMatch),
    .updOccupied(updOccupied), .strb(strb), .wrWay(wrWay),
    .s1Valid(s1Valid), .s2Valid(respValid)
  );

  btbDatapath #(
    .PC_W(PC_W), .OFS_W(OFS_W), .SETS(SETS), .WAYS(WAYS),
    .PTAG_W(PTAG_W), .TGT_W(TGT_W), .KIND_W(KIND_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .lkPc(lkPc), .updPc(updPc),
    .updTarget(updTarget), .updKind(updKind), .wrWay(wrWay),
    .s1Any(s1Any), .updSet(updSet), .updMatch(updMatch),
    .updOccupied(updOccupied), .wayRdEn(wayRdEn), .respHit(respHit),
    .respTarget(respTarget), .respKind(respKind), .respWays(respWays)
  );

  assign fastMiss = s1Valid & ~s1Any;

endmodule

// File: rtl/wayFilteredBtbChk.sv
module wayFilteredBtbChk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic            fastMiss,
  input logic [WAYS-1:0] wayRdEn,
  input logic            respValid,
  input logic            respHit,
  input logic [WAYS-1:0] respWays
);

  p_fast_miss_no_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    fastMiss |-> (wayRdEn == '0));

  p_fast_miss_needs_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    fastMiss |-> $past(lkValid));

  p_read_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|wayRdEn) |-> $past(lkValid));

  p_read_gives_resp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|wayRdEn) |=> respValid);

  p_resp_needs_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(|wayRdEn));

  p_hit_has_cand_r6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (respWays != '0));

endmodule

bind wayFilteredBtb wayFilteredBtbChk #(.WAYS(WAYS)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .fastMiss(fastMiss),
  .wayRdEn(wayRdEn), .respValid(respValid), .respHit(respHit),
  .respWays(respWays)
);

// File: tb/tb_wayFilteredBtb.sv
module tb_wayFilteredBtb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lkValid;
  logic [31:0] lkPc;
  logic        updValid;
  logic [31:0] updPc;
  logic [31:0] updTarget;
  logic [1:0]  updKind;
  logic        respValid, respHit, fastMiss;
  logic [31:0] respTarget;
  logic [1:0]  respKind;
  logic [3:0]  respWays, wayRdEn;

  always #5ns clk = ~clk;

  wayFilteredBtb dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget),
    .updKind(updKind), .respValid(respValid), .respHit(respHit),
    .respTarget(respTarget), .respKind(respKind), .respWays(respWays),
    .fastMiss(fastMiss), .wayRdEn(wayRdEn)
  );

  int    checks = 0;
  int    errors = 0;
  string scen   = "R1";

  // Behavioural reference state.
  bit          mV    [512][4];
  int unsigned mTag  [512][4];
  logic [31:0] mTgt  [512][4];
  logic [1:0]  mKind [512][4];
  int          mRr   [512];

  // Expected pipeline: a = one cycle after request, b = two cycles.
  bit          aValid, bValid, aHit, bHit;
  bit [3:0]    aCand, bCand;
  logic [31:0] aTgt, bTgt;
  logic [1:0]  aKind, bKind;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h", req, scen, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkPc(input int rest, input int ptag,
                                       input int set, input int low);
    return {rest[14:0], ptag[5:0], set[8:0], low[1:0]};
  endfunction

  task automatic pickVictim(input logic [31:0] pc, output int way, output bit rrUsed);
    int s;
    int unsigned t;
    s = int'(pc[10:2]);
    t = 32'(pc[31:11]);
    way = -1;
    rrUsed = 1'b0;
    for (int w = 0; w < 4; w++) if (mV[s][w] && mTag[s][w] == t) way = w;
    if (way < 0) for (int w = 3; w >= 0; w--) if (!mV[s][w]) way = w;
    if (way < 0) begin
      way = mRr[s];
      rrUsed = 1'b1;
    end
  endtask

  task automatic modelEdge(input bit lv, input logic [31:0] lpc, input bit uv,
                           input logic [31:0] upc, input logic [31:0] ut,
                           input logic [1:0] uk);
    int vic, s, us;
    bit rrUsed;
    int unsigned t;
    bValid = aValid && (aCand != 0);
    bCand = aCand; bHit = aHit; bTgt = aTgt; bKind = aKind;
    vic = -1;
    rrUsed = 1'b0;
    us = int'(upc[10:2]);
    if (uv) pickVictim(upc, vic, rrUsed);
    aValid = lv; aCand = '0; aHit = 1'b0; aTgt = '0; aKind = '0;
    if (lv) begin
      s = int'(lpc[10:2]);
      t = 32'(lpc[31:11]);
      for (int w = 0; w < 4; w++) begin
        if (mV[s][w] && mTag[s][w][5:0] == t[5:0] && !(uv && us == s && vic == w)) begin
          aCand[w] = 1'b1;
          if (mTag[s][w] == t) begin
            aHit = 1'b1; aTgt = mTgt[s][w]; aKind = mKind[s][w];
          end
        end
      end
    end
    if (uv) begin
      mV[us][vic] = 1'b1;
      mTag[us][vic] = 32'(upc[31:11]);
      mTgt[us][vic] = ut;
      mKind[us][vic] = uk;
      if (rrUsed) mRr[us] = (mRr[us] + 1) % 4;
    end
  endtask

  task automatic compareOut();
    check("R4", "fastMiss", 64'(fastMiss), 64'(aValid && aCand == 0));
    check("R5", "wayRdEn", 64'(wayRdEn), 64'(aValid ? aCand : 4'b0));
    check("R5", "respValid", 64'(respValid), 64'(bValid));
    if (bValid) begin
      check("R3", "respWays", 64'(respWays), 64'(bCand));
      check("R6", "respHit", 64'(respHit), 64'(bHit));
      if (bHit) begin
        check("R6", "respTarget", 64'(respTarget), 64'(bTgt));
        check("R6", "respKind", 64'(respKind), 64'(bKind));
      end
    end
  endtask

  task automatic doCycle(input bit lv, input logic [31:0] lpc, input bit uv,
                         input logic [31:0] upc, input logic [31:0] ut,
                         input logic [1:0] uk);
    lkValid = lv; lkPc = lpc; updValid = uv; updPc = upc; updTarget = ut; updKind = uk;
    @(posedge clk);
    modelEdge(lv, lpc, uv, upc, ut, uk);
    @(negedge clk);
    compareOut();
  endtask

  task automatic look(input logic [31:0] pc);
    doCycle(1'b1, pc, 1'b0, '0, '0, '0);
  endtask

  task automatic put(input logic [31:0] pc, input logic [31:0] tg, input logic [1:0] k);
    doCycle(1'b0, '0, 1'b1, pc, tg, k);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) doCycle(1'b0, '0, 1'b0, '0, '0, '0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    lkValid = 1'b0; lkPc = '0; updValid = 1'b0; updPc = '0; updTarget = '0; updKind = '0;
    for (int s = 0; s < 512; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) mV[s][w] = 1'b0;
    end
    aValid = 0; bValid = 0; aCand = 0; bCand = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    scen = "R1";
    check("R1", "respValid in reset", 64'(respValid), 64'd0);
    check("R1", "fastMiss in reset", 64'(fastMiss), 64'd0);
    check("R1", "wayRdEn in reset", 64'(wayRdEn), 64'd0);
    rstN = 1'b1;
    idle(1);
    // R1/R4: empty buffer, every lookup is a filtered miss.
    look(mkPc(1, 5, 3, 0));
    look(mkPc(0, 0, 0, 0));
    idle(2);

    // R7: install then look up in the very next cycle.
    scen = "R7";
    put(mkPc(1, 5, 3, 0), 32'h1000_0040, 2'd1);
    look(mkPc(1, 5, 3, 0));
    idle(2);

    // R2: low bits ignored; other partial tag filtered; other rest tag slow miss.
    scen = "R2";
    look(mkPc(1, 5, 3, 3));
    idle(2);
    look(mkPc(1, 6, 3, 0));
    look(mkPc(2, 5, 3, 0));
    look(mkPc(1, 5, 4, 0));
    idle(2);
    put(mkPc(9, 9, 9, 2), 32'hABCD_0000, 2'd3);
    look(mkPc(9, 9, 9, 1));
    idle(2);

    // R9: fill a set in way order, all share one partial tag.
    scen = "R9";
    for (int i = 0; i < 4; i++) put(mkPc(10 + i, 7, 7, 0), 32'h2000_0000 + i, 2'(i));
    for (int i = 0; i < 4; i++) look(mkPc(10 + i, 7, 7, 0));
    look(mkPc(99, 7, 7, 0));
    idle(2);

    // R10: full set, replacement by round robin.
    scen = "R10";
    put(mkPc(20, 7, 7, 0), 32'h3000_0000, 2'd0);
    put(mkPc(21, 8, 7, 0), 32'h3000_0004, 2'd1);
    for (int i = 0; i < 4; i++) look(mkPc(10 + i, 7, 7, 0));
    look(mkPc(20, 7, 7, 0));
    look(mkPc(21, 8, 7, 0));
    idle(2);

    // R8: rewrite of a stored tag keeps one copy.
    scen = "R8";
    put(mkPc(12, 7, 7, 0), 32'h4444_0000, 2'd2);
    look(mkPc(12, 7, 7, 0));
    look(mkPc(13, 7, 7, 0));
    look(mkPc(20, 7, 7, 0));
    idle(2);

    // R11: lookup and update to the same set in one cycle.
    scen = "R11";
    doCycle(1'b1, mkPc(20, 7, 7, 0), 1'b1, mkPc(30, 7, 7, 0), 32'h5555_0000, 2'd1);
    doCycle(1'b1, mkPc(30, 7, 7, 0), 1'b1, mkPc(31, 7, 7, 0), 32'h5555_0004, 2'd2);
    doCycle(1'b1, mkPc(1, 5, 3, 0), 1'b1, mkPc(1, 5, 3, 0), 32'h6666_0000, 2'd3);
    look(mkPc(1, 5, 3, 0));
    idle(2);

    // R5: a slow response and a fast miss coming out together.
    scen = "R5";
    look(mkPc(31, 7, 7, 0));
    look(mkPc(0, 63, 7, 0));
    look(mkPc(30, 7, 7, 0));
    look(mkPc(0, 1, 100, 0));
    idle(2);

    // Random stream over a few sets and tags.
    scen = "R3";
    for (int i = 0; i < 4000; i++) begin
      int sIdx;
      int setSel;
      bit lv, uv;
      logic [31:0] lp, up;
      sIdx = $urandom_range(0, 3);
      setSel = (sIdx == 0) ? 0 : (sIdx == 1) ? 3 : (sIdx == 2) ? 7 : 511;
      lv = ($urandom_range(0, 3) != 0);
      uv = ($urandom_range(0, 3) == 0);
      lp = mkPc($urandom_range(0, 3), $urandom_range(0, 3), setSel, $urandom_range(0, 3));
      sIdx = $urandom_range(0, 3);
      setSel = (sIdx == 0) ? 0 : (sIdx == 1) ? 3 : (sIdx == 2) ? 7 : 511;
      up = mkPc($urandom_range(0, 3), $urandom_range(0, 3), setSel, $urandom_range(0, 3));
      doCycle(lv, lp, uv, up, $urandom, 2'($urandom_range(0, 3)));
    end
    idle(3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule